// File: doc/BRIEF.md
# Half-Full-Gated Longword Byte Streamer

This controller moves 16-bit samples out of an external sample FIFO and onto an 8-bit, output-only byte port that uses an asynchronous four-phase strobe/ready handshake. It pops two samples and packs them into one 32-bit longword. The longword then goes out as four bytes. The strobe is active low and is driven by this block. The active-low ready comes back from the receiver.

Sending is gated on the FIFO's half-full flag, not on not-empty. Each start sends one complete longword. The flag is checked again before the next one, so longwords run back to back only while the FIFO stays at least half full and the receiver keeps answering. The controller can be held in reset in one of two ways, picked by a select input. One is a run control bit, where 0 means held. The other is an active-low external reset pin.

Top module: `fifo_byte_streamer`

## Requirements
- R1: A longword holds two consecutive samples. The first sample popped forms bits 15:0 and the second forms bits 31:16.
- R2: Bytes leave least significant first. Byte k of a longword carries bits 8k+7 down to 8k, for k = 0, 1, 2, 3.
- R3: While the controller is idle and the half-full input is low, the strobe stays high and no read pulse is issued.
- R4: Each start sends exactly four bytes. Half full is sampled again before the next longword, so longwords follow each other only while it stays high.
- R5: Both samples are popped before the first strobe of a longword, and no read is issued while a longword is on the port. A longword once started is finished even if half full drops.
- R6: No read pulse is issued while the empty input is high. If the FIFO runs empty after the first sample, the controller waits for the second sample before any strobe.
- R7: Each byte runs the same handshake. Strobe goes low and stays low, with the data stable, until ready is seen low. Strobe then goes high, and the next strobe waits until ready has been seen high again. Ready passes through a synchronizer first.
- R8: With the reset select at 0, a run bit of 0 holds the controller in reset. With the select at 1, a low external reset pin holds it in reset and the run bit has no effect. While held, the strobe is high and no reads occur, and a byte in progress is dropped.
- R9: Sample bits pass through unchanged. A right-justified 12-bit value, with or without sign extension, arrives exactly as it was stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Global synchronous reset, active low |
| run_ctl | input | 1 | Run bit: 0 holds the controller in reset when selected |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| rst_sel | input | 1 | Reset source: 0 selects run_ctl, 1 selects ext_rst_n |
| fifo_empty | input | 1 | FIFO holds no samples |
| fifo_half | input | 1 | FIFO is at least half full |
| fifo_rd | output | 1 | One-cycle pop request; data is valid on the next clock |
| fifo_data | input | SAMPLE_W | Sample returned by the FIFO |
| tx_data | output | 8 | Byte on the port, always driven |
| tx_stb_n | output | 1 | Byte strobe, active low |
| tx_rdy_n | input | 1 | Receiver ready, active low, asynchronous |

## Verification
The assertions check the cycle-level rules on every clock. There are no reads while the FIFO is empty or while a byte is on the port. A low strobe holds its data and its level until synchronized ready arrives. A new strobe edge follows only a ready-high sample, and the controller stays quiet while held in reset. Several behaviours show only in the bench's scenarios: the packing and byte order of the data, the exact count of bytes per half-full start, completion of a longword after half full drops, waiting for a late second sample, and the two reset sources with their selector.

// File: rtl/fbs_pkg.sv
// Shared types for the half-full-gated byte streamer.
// Assumes: byte lanes are 8 bits wide; samples are a multiple of 4 bits.
package fbs_pkg;

    localparam int BYTE_W = 8;

    // Sample fetch and packing sequence
    typedef enum logic [2:0] {
        PK_IDLE,     // waiting for half full
        PK_LO,       // first sample on the bus, latch low half
        PK_WAIT_HI,  // FIFO ran empty before the second pop
        PK_HI,       // second sample on the bus, latch high half
        PK_HOLD      // longword owned by the byte sender
    } pack_st_t;

    // Per-byte four-phase handshake
    typedef enum logic [1:0] {
        BT_IDLE,     // no longword, or waiting for ready high
        BT_STB,      // strobe low, waiting for ready low
        BT_REL       // strobe released, waiting for ready high
    } byte_st_t;

endpackage

// File: rtl/sync_bits.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level, so single-bit metastability settling
// is sufficient; the reset value is what downstream logic treats as "safe".
module sync_bits #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/word_pack.sv
// Pops two samples from the FIFO once half full is seen and holds them as
// one longword (first sample low, second high) until the sender is done.
// Assumes: FIFO data is valid the clock after a one-cycle read pulse.
module word_pack
    import fbs_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic            clk,
    input  logic            ctl_rst_n,
    input  logic            fifo_empty,
    input  logic            fifo_half,
    output logic            fifo_rd,
    input  logic [SW-1:0]   fifo_data,
    input  logic            lw_done,
    output logic            lw_valid,
    output logic [2*SW-1:0] lw_data
);
    pack_st_t      st, st_nx;
    logic [SW-1:0] lo_q, hi_q;
    logic          rd_raw;

    // Next-state and read-pulse decode
    always_comb begin
        st_nx  = st;
        rd_raw = 1'b0;
        unique case (st)
            PK_IDLE: if (fifo_half && !fifo_empty) begin
                rd_raw = 1'b1;
                st_nx  = PK_LO;
            end
            PK_LO: if (!fifo_empty) begin
                rd_raw = 1'b1;
                st_nx  = PK_HI;
            end else begin
                st_nx  = PK_WAIT_HI;
            end
            PK_WAIT_HI: if (!fifo_empty) begin
                rd_raw = 1'b1;
                st_nx  = PK_HI;
            end
            PK_HI:   st_nx = PK_HOLD;
            PK_HOLD: if (lw_done) st_nx = PK_IDLE;
            default: st_nx = PK_IDLE;
        endcase
    end

    // No pops while the controller is held in reset
    assign fifo_rd = rd_raw && ctl_rst_n;

    // State register
    always_ff @(posedge clk) begin
        if (!ctl_rst_n) st <= PK_IDLE;
        else            st <= st_nx;
    end

    // Capture each half of the longword the cycle its sample is valid
    always_ff @(posedge clk) begin
        if (!ctl_rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (st == PK_LO) lo_q <= fifo_data;
            if (st == PK_HI) hi_q <= fifo_data;
        end
    end

    assign lw_valid = (st == PK_HOLD);
    assign lw_data  = {hi_q, lo_q};
endmodule

// File: rtl/byte_tx.sv
// Sends a held longword as bytes, least significant first, with a
// four-phase strobe/ready handshake per byte.
// Assumes: rdy_s is already synchronized; 1 means "not ready".
module byte_tx
    import fbs_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              ctl_rst_n,
    input  logic              lw_valid,
    input  logic [WORD_W-1:0] lw_data,
    input  logic              rdy_s,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_stb_n,
    output logic              lw_done
);
    localparam int NB    = WORD_W / BYTE_W;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

    byte_st_t          st;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] lanes [NB];

    // Split the longword into byte lanes
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = lw_data[g*BYTE_W +: BYTE_W];
    end

    assign tx_data  = lanes[idx];
    assign tx_stb_n = (st != BT_STB);
    assign lw_done  = (st == BT_REL) && rdy_s && (idx == LAST);

    // Handshake sequencer and byte index
    always_ff @(posedge clk) begin
        if (!ctl_rst_n) begin
            st  <= BT_IDLE;
            idx <= '0;
        end else begin
            unique case (st)
                BT_IDLE: if (lw_valid && rdy_s) st <= BT_STB;
                BT_STB:  if (!rdy_s) st <= BT_REL;
                BT_REL:  if (rdy_s) begin
                    if (idx == LAST) begin
                        idx <= '0;
                        st  <= BT_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= BT_STB;
                    end
                end
                default: st <= BT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fifo_byte_streamer.sv
// Top: half-full-gated FIFO drain onto an output-only strobe/ready byte port.
// Assumes: half-full and empty flags are synchronous to clk; ready and the
// external reset pin are asynchronous and are synchronized here.
module fifo_byte_streamer
    import fbs_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_ctl,
    input  logic                ext_rst_n,
    input  logic                rst_sel,
    input  logic                fifo_empty,
    input  logic                fifo_half,
    output logic                fifo_rd,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_stb_n,
    input  logic                tx_rdy_n
);
    localparam int WORD_W = 2 * SAMPLE_W;

    logic              rst_src;
    logic              ctl_rst_n;
    logic              rdy_s;
    logic              lw_valid;
    logic              lw_done;
    logic [WORD_W-1:0] lw_data;

    // Pick the controller reset source
    assign rst_src = rst_sel ? ext_rst_n : run_ctl;

    sync_bits #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rst_src),
        .dout (ctl_rst_n)
    );

    sync_bits #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tx_rdy_n),
        .dout (rdy_s)
    );

    word_pack #(.SW(SAMPLE_W)) u_pack (
        .clk       (clk),
        .ctl_rst_n (ctl_rst_n),
        .fifo_empty(fifo_empty),
        .fifo_half (fifo_half),
        .fifo_rd   (fifo_rd),
        .fifo_data (fifo_data),
        .lw_done   (lw_done),
        .lw_valid  (lw_valid),
        .lw_data   (lw_data)
    );

    byte_tx #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .ctl_rst_n(ctl_rst_n),
        .lw_valid (lw_valid),
        .lw_data  (lw_data),
        .rdy_s    (rdy_s),
        .tx_data  (tx_data),
        .tx_stb_n (tx_stb_n),
        .lw_done  (lw_done)
    );
endmodule

// File: rtl/fifo_byte_streamer_chk.sv
// Protocol checker for the byte streamer, bound onto the top module.
module fifo_byte_streamer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_rst_n,
    input logic       rdy_s,
    input logic       fifo_empty,
    input logic       fifo_rd,
    input logic [7:0] tx_data,
    input logic       tx_stb_n
);
    // R6: never pop an empty FIFO
    assert_no_read_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R5: no pops while a byte is on the port
    assert_no_read_in_byte_R5: assert property (@(posedge clk) disable iff (!rst_n || !ctl_rst_n)
        !tx_stb_n |-> !fifo_rd);

    // R7: data holds while strobe is low
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !ctl_rst_n)
        !tx_stb_n |=> (tx_stb_n || $stable(tx_data)));

    // R7: strobe stays low until ready is seen
    assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !ctl_rst_n)
        (!tx_stb_n && rdy_s) |=> !tx_stb_n);

    // R7: a new strobe only after ready was seen high
    assert_strobe_after_idle_R7: assert property (@(posedge clk) disable iff (!rst_n || !ctl_rst_n)
        $fell(tx_stb_n) |-> $past(rdy_s));

    // R8: held controller issues no pops and releases strobe
    assert_quiet_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rst_n |-> !fifo_rd);
    assert_strobe_off_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rst_n |=> tx_stb_n);
endmodule

bind fifo_byte_streamer fifo_byte_streamer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rst_n (ctl_rst_n),
    .rdy_s     (rdy_s),
    .fifo_empty(fifo_empty),
    .fifo_rd   (fifo_rd),
    .tx_data   (tx_data),
    .tx_stb_n  (tx_stb_n)
);

// File: tb/fifo_byte_streamer_test.sv
// Directed bench: a FIFO model, a receiver model and one task per scenario.
module fifo_byte_streamer_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_ctl = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        rst_sel = 1'b0;
    logic        fifo_empty, fifo_half, fifo_rd;
    logic [15:0] fifo_data = '0;
    logic [7:0]  tx_data;
    logic        tx_stb_n;
    logic        tx_rdy_n = 1'b1;

    always #2 clk = ~clk;

    fifo_byte_streamer uut (
        .clk(clk), .rst_n(rst_n), .run_ctl(run_ctl), .ext_rst_n(ext_rst_n),
        .rst_sel(rst_sel), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
        .fifo_rd(fifo_rd), .fifo_data(fifo_data), .tx_data(tx_data),
        .tx_stb_n(tx_stb_n), .tx_rdy_n(tx_rdy_n)
    );

    int tests = 0, fails = 0;

    // FIFO model
    logic [15:0] mem [0:1023];
    int  wp = 0, rp = 0;
    logic force_half = 1'b0;
    assign fifo_empty = (wp == rp);
    assign fifo_half  = force_half || ((wp - rp) >= HALF);

    always @(posedge clk) begin
        if (fifo_rd && (wp != rp)) begin
            fifo_data <= mem[rp];
            rp <= rp + 1;
        end
    end

    // Receiver model and monitors
    logic [7:0] rx_buf [0:1023];
    int  rx_cnt = 0, rx_chk = 0, exp_idx = 0;
    int  rx_lag = 0, rx_early = 0;
    logic rx_hold = 1'b0;
    int  mon_rd = 0, mon_stb = 0;
    logic prev_stb = 1'b1;

    always begin
        @(negedge clk);
        if (rst_n && !tx_stb_n && tx_rdy_n && !rx_hold) begin
            rx_buf[rx_cnt] = tx_data;
            rx_cnt++;
            tx_rdy_n = 1'b0;
            do @(negedge clk); while (!tx_stb_n);
            for (int k = 0; k < rx_lag; k++) begin
                @(negedge clk);
                if (!tx_stb_n) rx_early++;
            end
            tx_rdy_n = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (fifo_rd) mon_rd++;
        if (prev_stb && !tx_stb_n) mon_stb++;
        prev_stb = tx_stb_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        mem[wp] = v;
        wp++;
    endtask

    task automatic push_n(input int n, input int seed);
        for (int i = 0; i < n; i++) push(16'((seed * 40503 + i * 4099) & 16'hFFFF));
    endtask

    task automatic flush();
        wp = rp;
        exp_idx = rp;
        rx_chk = rx_cnt;
    endtask

    task automatic settle();
        int quiet = 0;
        int last = rx_cnt;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (tx_stb_n && !fifo_rd && rx_cnt == last && tx_rdy_n) quiet++;
            else begin quiet = 0; last = rx_cnt; end
            if (quiet >= 40) break;
        end
    endtask

    task automatic wait_stb_low();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!tx_stb_n) break;
        end
    endtask

    // Compare every received longword with the FIFO contents in pop order
    task automatic verify_rx(input string req);
        while (rx_chk + 4 <= rx_cnt) begin
            for (int b = 0; b < 4; b++) begin
                logic [15:0] s;
                logic [7:0]  e;
                s = mem[exp_idx + b / 2];
                e = s[(b % 2) * 8 +: 8];
                check(rx_buf[rx_chk + b] == e, req, "byte value/order",
                      rx_buf[rx_chk + b], e);
            end
            exp_idx += 2;
            rx_chk += 4;
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(tx_stb_n == 1'b1, "R8", "strobe in reset", tx_stb_n, 1);
        check(fifo_rd == 1'b0, "R8", "read in reset", fifo_rd, 0);
        rst_n = 1'b1;
        run_ctl = 1'b1;
        repeat (6) @(negedge clk);
        check(tx_stb_n == 1'b1, "R3", "strobe idle after reset", tx_stb_n, 1);
    endtask

    task automatic t_below_half();
        push_n(HALF - 1, 1);
        settle();
        check(mon_rd == 0, "R3", "reads below half", mon_rd, 0);
        check(mon_stb == 0, "R3", "strobes below half", mon_stb, 0);
        check(rx_cnt == 0, "R3", "bytes below half", rx_cnt, 0);
    endtask

    task automatic t_single();
        int b0 = rx_cnt;
        int r0 = mon_rd;
        push_n(1, 2);
        settle();
        check(rx_cnt - b0 == 4, "R4", "bytes per start", rx_cnt - b0, 4);
        check(mon_rd - r0 == 2, "R5", "pops per longword", mon_rd - r0, 2);
        check(wp - rp == HALF - 2, "R5", "longword finished after half dropped",
              wp - rp, HALF - 2);
        verify_rx("R1");
    endtask

    task automatic t_burst();
        int b0 = rx_cnt;
        int s0 = mon_stb;
        rx_lag = 4;
        push_n(8, 3);
        settle();
        rx_lag = 0;
        check(rx_cnt - b0 == 16, "R4", "back-to-back bytes", rx_cnt - b0, 16);
        check(mon_stb - s0 == 16, "R7", "one strobe per byte", mon_stb - s0, 16);
        check(rx_early == 0, "R7", "strobe before ready high", rx_early, 0);
        check(wp - rp == HALF - 2, "R4", "stop under half", wp - rp, HALF - 2);
        verify_rx("R2");
    endtask

    task automatic t_stall();
        logic [7:0] d0;
        int r0 = mon_rd;
        rx_hold = 1'b1;
        push_n(2, 4);
        wait_stb_low();
        d0 = tx_data;
        repeat (30) @(negedge clk);
        check(tx_stb_n == 1'b0, "R7", "strobe held without ready", tx_stb_n, 0);
        check(tx_data == d0, "R7", "data held without ready", tx_data, d0);
        check(mon_rd - r0 == 2, "R5", "no pops while stalled", mon_rd - r0, 2);
        rx_hold = 1'b0;
        settle();
        verify_rx("R2");
    endtask

    task automatic t_empty();
        int r0, s0, b0;
        flush();
        force_half = 1'b1;
        r0 = mon_rd; s0 = mon_stb; b0 = rx_cnt;
        settle();
        check(mon_rd == r0, "R6", "read while empty", mon_rd - r0, 0);
        push(16'h1234);
        settle();
        check(mon_rd - r0 == 1, "R6", "one pop then wait", mon_rd - r0, 1);
        check(mon_stb == s0, "R6", "strobe before second sample", mon_stb - s0, 0);
        push(16'hABCD);
        settle();
        check(rx_cnt - b0 == 4, "R6", "longword after late sample", rx_cnt - b0, 4);
        verify_rx("R1");
        force_half = 1'b0;
    endtask

    task automatic t_width();
        logic [15:0] v [8];
        v = '{16'h0ABC, 16'h0FFF, 16'h0001, 16'hF800,
              16'hFFFF, 16'h0800, 16'h07FF, 16'h0000};
        for (int i = 0; i < 8; i++) push(v[i]);
        settle();
        verify_rx("R9");
        check(rx_chk == rx_cnt, "R9", "all bytes compared", rx_cnt - rx_chk, 0);
    endtask

    task automatic t_run_reset();
        int r0;
        rx_hold = 1'b1;
        push_n(2, 5);
        wait_stb_low();
        run_ctl = 1'b0;
        repeat (5) @(negedge clk);
        check(tx_stb_n == 1'b1, "R8", "run bit low drops byte", tx_stb_n, 1);
        flush();
        rx_hold = 1'b0;
        r0 = mon_rd;
        push_n(HALF, 6);
        repeat (20) @(negedge clk);
        check(mon_rd == r0, "R8", "no pops while held", mon_rd - r0, 0);
        check(tx_stb_n == 1'b1, "R8", "strobe while held", tx_stb_n, 1);
        run_ctl = 1'b1;
        settle();
        check(rx_cnt - rx_chk == 4, "R8", "resumes after run", rx_cnt - rx_chk, 4);
        verify_rx("R8");
    endtask

    task automatic t_ext_reset();
        int b0;
        rst_sel = 1'b1;
        run_ctl = 1'b0;
        b0 = rx_cnt;
        push_n(2, 7);
        settle();
        check(rx_cnt - b0 == 4, "R8", "run bit ignored when pin selected", rx_cnt - b0, 4);
        verify_rx("R8");
        rx_hold = 1'b1;
        push_n(2, 8);
        wait_stb_low();
        ext_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(tx_stb_n == 1'b1, "R8", "pin reset drops byte", tx_stb_n, 1);
        flush();
        rx_hold = 1'b0;
        ext_rst_n = 1'b1;
        run_ctl = 1'b1;
        repeat (5) @(negedge clk);
        rst_sel = 1'b0;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_below_half();
        t_single();
        t_burst();
        t_stall();
        t_empty();
        t_width();
        t_run_reset();
        t_ext_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule